// File: doc/BRIEF.md
# Free-Running Timer Counter with Coherent Two-Byte Read

The block is a 16-bit up-counter that keeps running on its own. It advances once every four bus clock cycles, paced by a fixed divide-by-four prescaler. An 8-bit processor reads it through two read-only byte registers. Because the processor fetches the value one byte at a time, the counter could roll over between the two fetches. To prevent that, a read of the upper byte freezes a copy of the lower byte. The following lower-byte read returns that copy, which keeps the pair consistent. That lower-byte read also releases the copy, so the lower byte becomes live again.

A flag output goes high when the counter wraps from its top value back to zero. The flag is cleared through a dedicated input, which is the route the primary timer register path uses. Reads on this register pair never touch the counter or the flag. Writes to the pair are dropped.

A processor that wants a coherent 16-bit snapshot reads the upper byte first and the lower byte second. A processor that needs only a fine-grained time stamp may read the lower byte alone.

Top module: `tmr_coherent_read`

## Requirements
- R1: The internal reset is asserted asynchronously and released on the second rising clock edge after `rst_n` goes high. While it is asserted, the counter holds 0xFFFC, so a high-byte read returns 0xFF and a low-byte read returns 0xFC. Also during reset, `ovf_flag` is 0, `rdata` is 0x00 and the low-byte latch is transparent.
- R2: Counting starts on the first rising edge after the internal reset is released. From then on, the counter increases by one on every fourth rising edge. The first increment lands on the fourth counting edge. The counter wraps from 0xFFFF to 0x0000.
- R3: `rdata` is registered. A read sampled on a rising edge shows its data after that edge, and `rdata` is 0x00 in any cycle that follows no read. A read of address 0x1A returns bits 15..8 of the counter as they stood on the sampling edge. A read of any address other than 0x1A or 0x1B returns 0x00.
- R4: A write strobe to any address leaves the counter, `ovf_flag`, the latch contents and the latch state unchanged.
- R5: When the latch is transparent, a read of 0x1A captures bits 7..0 of the counter from the same sampling edge. Further reads of 0x1A before the next read of 0x1B keep the first captured value.
- R6: When the latch is transparent, a read of 0x1B returns the live bits 7..0 of the counter. When the latch is frozen, a read of 0x1B returns the held value and then makes the latch transparent again.
- R7: `ovf_flag` rises on the edge where the counter wraps from 0xFFFF to 0x0000, and it then stays high.
- R8: `ovf_clr` sampled high clears `ovf_flag`. If a wrap happens on the same edge, the set wins.
- R9: Reads of either register, in any order and any number of times, change neither the counter sequence nor `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe (ignored by this register pair) |
| wdata | input | 8 | Write data (ignored) |
| ovf_clr | input | 1 | Clears the overflow flag |
| rdata | output | 8 | Registered read data |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The assertions assume a single strobe per cycle. A read and a write are never asserted together. The address is stable while a strobe is high, and no read is issued while the internal reset is still asserted. The stimulus drives every strobe for exactly one cycle on a falling edge and never overlaps reads with writes. It waits three cycles after releasing `rst_n` before the first access. `ovf_clr` is pulsed only away from a wrap edge, so the clear path is checked in isolation.

// File: rtl/tmr_cr_pkg.sv
package tmr_cr_pkg;
  // Register selection decoded from the bus address.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2
  } tmr_sel_e;

  localparam int unsigned TMR_CNT_W  = 16;
  localparam int unsigned TMR_BYTE_W = 8;
  localparam int unsigned TMR_PRE_W  = 2;
endpackage

// File: rtl/tmr_cr_rst_sync.sv
module tmr_cr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_cr_prescaler.sv
module tmr_cr_prescaler #(
  parameter int unsigned PRE_W = tmr_cr_pkg::TMR_PRE_W
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = (pre_q == PRE_TOP);

  // R2: a tick never lasts two cycles in a row
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_cr_counter.sv
module tmr_cr_counter #(
  parameter int unsigned     CNT_W   = tmr_cr_pkg::TMR_CNT_W,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             cnt_en;
  logic             wrap;

  always_comb begin
    cnt_en = tick;
    wrap   = cnt_en && (cnt_q == CNT_TOP);
    cnt_d  = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
    ovf_d = ovf_q;
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt == CNT_TOP)) |=> ovf);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(tick && (cnt == CNT_TOP))) |=> !ovf);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/tmr_cr_lo_latch.sv
module tmr_cr_lo_latch #(
  parameter int unsigned BYTE_W = tmr_cr_pkg::TMR_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              rel_en,
  input  logic [BYTE_W-1:0] live_lo,
  output logic [BYTE_W-1:0] lo_view,
  output logic              frozen
);
  logic [BYTE_W-1:0] held_q, held_d;
  logic              frz_q, frz_d;
  logic              held_en;

  always_comb begin
    held_en = cap_en && !frz_q;
    held_d  = held_q;
    frz_d   = frz_q;
    if (held_en) begin
      held_d = live_lo;
      frz_d  = 1'b1;
    end else if (rel_en) begin
      frz_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      frz_q  <= 1'b0;
    end else begin
      if (held_en) held_q <= held_d;
      frz_q <= frz_d;
    end
  end

  assign lo_view = frz_q ? held_q : live_lo;
  assign frozen  = frz_q;

  // R5: a repeated capture request leaves the frozen byte alone
  p_hold_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && cap_en) |=> (frz_q && (lo_view == $past(lo_view))));
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_q && cap_en) |=> (frz_q && (lo_view == $past(live_lo))));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> !frz_q);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_en && rel_en));
endmodule

// File: rtl/tmr_cr_decode.sv
module tmr_cr_decode #(
  parameter int unsigned        ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]  HI_ADDR = 8'h1A,
  parameter logic [ADDR_W-1:0]  LO_ADDR = 8'h1B
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_en,
  output tmr_cr_pkg::tmr_sel_e sel
);
  always_comb begin
    sel = tmr_cr_pkg::SEL_NONE;
    if (rd_en) begin
      if (addr == HI_ADDR)      sel = tmr_cr_pkg::SEL_HI;
      else if (addr == LO_ADDR) sel = tmr_cr_pkg::SEL_LO;
    end
  end
endmodule

// File: rtl/tmr_coherent_read.sv
module tmr_coherent_read #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h1A,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h1B,
  parameter logic [15:0] RST_VAL = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              ovf_clr,
  output logic [7:0]        rdata,
  output logic              ovf_flag
);
  import tmr_cr_pkg::*;
  localparam int unsigned CNT_W  = TMR_CNT_W;
  localparam int unsigned BYTE_W = TMR_BYTE_W;

  logic               rst_i;
  logic               tick;
  logic [CNT_W-1:0]   cnt;
  logic               ovf;
  logic [BYTE_W-1:0]  lo_view;
  logic               frozen;
  tmr_sel_e           sel;
  logic [BYTE_W-1:0]  rd_d, rd_q;

  tmr_cr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_i));

  tmr_cr_prescaler #(.PRE_W(TMR_PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_i), .tick(tick));

  tmr_cr_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_i), .tick(tick), .ovf_clr(ovf_clr),
    .cnt(cnt), .ovf(ovf));

  tmr_cr_decode #(.ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_dec (
    .addr(addr), .rd_en(rd_en), .sel(sel));

  tmr_cr_lo_latch #(.BYTE_W(BYTE_W)) u_lat (
    .clk(clk), .rst_n(rst_i),
    .cap_en(sel == SEL_HI), .rel_en(sel == SEL_LO),
    .live_lo(cnt[BYTE_W-1:0]), .lo_view(lo_view), .frozen(frozen));

  always_comb begin
    case (sel)
      SEL_HI:  rd_d = cnt[CNT_W-1 -: BYTE_W];
      SEL_LO:  rd_d = lo_view;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata    = rd_q;
  assign ovf_flag = ovf;

  // R3: high-byte data follows the counter sampled with the strobe
  p_hi_read_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_en && addr == HI_ADDR) |=> (rdata == $past(cnt[CNT_W-1 -: BYTE_W])));
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_en |=> (rdata == '0));
  // R4: written data never reaches the low counter byte
  p_wr_data_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && !rd_en && !tick && (wdata != cnt[7:0])) |=> (cnt[7:0] != $past(wdata)));
  p_wr_latch_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && !rd_en) |=> (frozen == $past(frozen)));
  // R9: reads leave the flag alone when no wrap occurs
  p_rd_flag_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_en && !ovf_clr && !(tick && cnt == '1)) |=> (ovf_flag == $past(ovf_flag)));
endmodule

// File: tb/tmr_coherent_read_test.sv
module tmr_coherent_read_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       rd_en, wr_en, ovf_clr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ovf_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_coherent_read uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .ovf_clr(ovf_clr), .rdata(rdata), .ovf_flag(ovf_flag));

  // Reference model built from the requirements.
  logic [1:0]  m_sync;
  logic [1:0]  m_pre;
  logic [15:0] m_cnt;
  logic        m_ovf;
  logic        m_froz;
  logic [7:0]  m_held;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00; m_pre <= 2'd0; m_cnt <= 16'hFFFC; m_ovf <= 1'b0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        m_pre <= m_pre + 2'd1;
        if (m_pre == 2'd3) m_cnt <= m_cnt + 16'd1;
        if (m_pre == 2'd3 && m_cnt == 16'hFFFF) m_ovf <= 1'b1;
        else if (ovf_clr)                        m_ovf <= 1'b0;
      end
    end
  end

  // Scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    if (a == 8'h1A) begin
      e = m_cnt[15:8];
      if (!m_froz) begin m_held = m_cnt[7:0]; m_froz = 1'b1; end
    end else if (a == 8'h1B) begin
      e = m_froz ? m_held : m_cnt[7:0];
      m_froz = 1'b0;
    end else begin
      e = 8'h00;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk_flag(input string tag);
    @(negedge clk);
    checks++;
    if (ovf_flag !== m_ovf) begin
      errors++;
      $display("FAIL %s ovf_flag actual=%0b expected=%0b", tag, ovf_flag, m_ovf);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = 8'h00; rd_en = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    ovf_clr = 1'b0; m_froz = 1'b0; m_held = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== 8'h00 || ovf_flag !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%02h/%0b expected=00/0", rdata, ovf_flag);
    end
    rst_n = 1'b1;
    idle(2);
    // R1: reset value seen on the first coherent pair
    do_read(8'h1A, "R1 reset high byte");
    do_read(8'h1B, "R1 reset low byte");
    chk_flag("R1 flag after reset");
    // R6: transparent low-byte reads track the counter
    for (int i = 0; i < 5; i++) begin
      do_read(8'h1B, "R6 transparent low");
      idle(i);
    end
    // R5: repeated high reads keep the first capture
    do_read(8'h1A, "R5 first high");
    idle(9);
    do_read(8'h1A, "R5 repeat high");
    do_read(8'h1A, "R5 repeat high again");
    do_read(8'h1B, "R6 held low");
    do_read(8'h1B, "R6 released low");
    // R3: unmapped address reads zero
    do_read(8'h1C, "R3 unmapped");
    do_read(8'h00, "R3 unmapped zero");
    // R4: writes change nothing, also while frozen
    do_read(8'h1A, "R4 high before write");
    do_write(8'h1B, 8'h00);
    do_write(8'h1A, 8'h55);
    idle(6);
    do_read(8'h1B, "R4 held low after writes");
    do_write(8'h1A, 8'h00);
    do_read(8'h1A, "R4 high after write");
    do_read(8'h1B, "R4 low after write");
    chk_flag("R4 flag after writes");
    // R7: wait for the wrap
    while (!m_ovf) @(negedge clk);
    chk_flag("R7 flag on wrap");
    do_read(8'h1A, "R2 high after wrap");
    do_read(8'h1B, "R2 low after wrap");
    // R8: clear
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk_flag("R8 flag cleared");
    // R9: read storm does not disturb counter or flag
    for (int i = 0; i < 40; i++) begin
      do_read((i % 3 == 0) ? 8'h1B : 8'h1A, "R9 read storm");
    end
    chk_flag("R9 flag after reads");
    // R2: long run then coherent read
    idle(1001);
    do_read(8'h1A, "R2 high after run");
    do_read(8'h1B, "R2 low after run");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 scoreboard left actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule